// File: doc/BRIEF.md
# Automatic Transmit/Receive Pin Switcher

This block drives the output values of several banks of general-purpose daughterboard pins. Each bank keeps its own select mask, a transmit pattern, a receive pattern and a plain output register. With automatic switching off, every pin shows the plain output register. With switching on, each pin whose select bit is set shows the transmit pattern or the receive pattern, depending on a single transmit/receive indication. All other pins keep showing the plain output register.

The indication follows the occupancy of the transmit FIFO. It moves towards transmit while the FIFO holds data and towards receive once the FIFO is empty. Each move waits for its own programmable number of clock ticks. One count applies on entering transmit and another on leaving it. A reversal during the wait restarts the count for the new direction, and the indication does not change on the way. The per-pin output enables come from outside the block and pass straight through. All registers are written over a single-cycle write bus.

Top module: `trx_pin_switcher`

## Requirements
- R1: While `rst` is high and after it is released, all select masks, patterns, output registers and both delays are zero, switching is disabled and the indication is receive, so `pin_out` is all zeros.
- R2: A write with `wr_addr` below 16 targets bank `wr_addr[3:2]` (bank b owns `pin_out[16b+15:16b]`). Register `wr_addr[1:0]` is 0 for the select mask, 1 for the transmit pattern, 2 for the receive pattern and 3 for the plain output register. Each register takes `wr_data[15:0]` and affects only its own bank.
- R3: A write to the plain output register changes only those bits i for which `wr_data[16+i]` is 1, setting them to `wr_data[i]`.
- R4: Address 16 holds the switching enable in `wr_data[0]`. While it is 0, `pin_out` equals the plain output registers whatever the masks and the FIFO state.
- R5: While switching is enabled, a pin with its select bit clear shows the plain output register, and a pin with its select bit set shows the pattern chosen by the indication.
- R6: With both delays zero, the indication becomes transmit on the clock edge that first sees `fifo_empty` low and receive on the edge that first sees it high. Transmit selects the transmit pattern and receive selects the receive pattern.
- R7: Address 17 holds the rise delay D (`wr_data[15:0]`). After `fifo_empty` falls, the indication stays receive for D edges and becomes transmit on edge D+1.
- R8: Address 18 holds the fall delay F. After `fifo_empty` rises, the indication stays transmit for F edges and becomes receive on edge F+1.
- R9: If `fifo_empty` returns to its former level before a pending delay expires, the indication does not change and the count restarts. A later change again waits the full delay.
- R10: `pin_oe` always equals `oe_in`, whatever the register contents, the enable and the indication.
- R11: Writes to addresses 19 to 31 change no register and so leave `pin_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Write data; upper half is the bit enable for plain output writes |
| fifo_empty | input | 1 | High when the transmit FIFO holds no data |
| oe_in | input | 64 | Per-pin output enables from the direction register |
| pin_out | output | 64 | Pin output values, four banks of 16 |
| pin_oe | output | 64 | Per-pin output enables, passed through |

## Verification
The bench counts the exact edge on which the indication flips for non-zero rise and fall delays. An off-by-one counter would flip one cycle early or one cycle late. It reverses `fifo_empty` in the middle of a wait. A design that keeps counting across the reversal would reach transmit early, and one that follows the FIFO with no wait would pulse the pins. It applies partial bit-enable writes to the plain output register, where a design ignoring the enable half would overwrite bits that must hold. It checks that unselected pins, a disabled switch, unmapped addresses and a reset in the middle of traffic leave the outputs exactly as the plain output registers dictate.

// File: rtl/trx_sw_pkg.sv
package trx_sw_pkg;

   // register selector inside one bank: low two address bits
   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_TXV  = 2'd1,
      SEL_RXV  = 2'd2,
      SEL_IO   = 2'd3
   } bank_sel_e;

   // control registers follow the bank block
   localparam int CTRL_EN_OFS   = 0;
   localparam int CTRL_RISE_OFS = 1;
   localparam int CTRL_FALL_OFS = 2;
   localparam int CTRL_REGS     = 3;
   localparam int REGS_PER_BANK = 4;
   localparam int BUS_W         = 32;

endpackage

// File: rtl/trx_sw_dir_timer.sv
module trx_sw_dir_timer #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tx_pending,
   input  logic [DLY_W-1:0] dly_rise,
   input  logic [DLY_W-1:0] dly_fall,
   output logic             tx_mode
);

   logic [DLY_W-1:0] cnt_q;
   logic             mode_q;
   logic [DLY_W-1:0] limit;

   assign limit   = tx_pending ? dly_rise : dly_fall;
   assign tx_mode = mode_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= 1'b0;
         cnt_q  <= '0;
      end else if (tx_pending == mode_q) begin
         cnt_q <= '0;
      end else if (cnt_q >= limit) begin
         mode_q <= tx_pending;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // the indication only ever moves toward the requested direction
   assert_flip_toward_request_R6: assert property (@(posedge clk) disable iff (rst)
      (mode_q != $past(mode_q)) |-> (mode_q == $past(tx_pending)));

   // entering transmit only after the rise wait has elapsed
   assert_rise_waits_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(mode_q) |-> ($past(cnt_q) >= $past(dly_rise)));

   // leaving transmit only after the fall wait has elapsed
   assert_fall_waits_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(mode_q) |-> ($past(cnt_q) >= $past(dly_fall)));

   // a request matching the present state holds the state and clears the wait
   assert_reversal_holds_R9: assert property (@(posedge clk) disable iff (rst)
      (tx_pending == mode_q) |=> ($stable(mode_q) && cnt_q == '0));

endmodule

// File: rtl/trx_sw_bank.sv
module trx_sw_bank
   import trx_sw_pkg::*;
#(
   parameter int BANK_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_hit,
   input  logic [1:0]       wr_sel,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             auto_en,
   input  logic             tx_mode,
   output logic [BANK_W-1:0] pin_out
);

   localparam int BEN_LSB = BUS_W / 2;

   logic [BANK_W-1:0] mask_q, txv_q, rxv_q, io_q;
   logic [BANK_W-1:0] io_ben, io_val, auto_val;

   assign io_ben = wr_data[BEN_LSB +: BANK_W];
   assign io_val = wr_data[BANK_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q <= '0;
         txv_q  <= '0;
         rxv_q  <= '0;
         io_q   <= '0;
      end else if (wr_hit) begin
         case (bank_sel_e'(wr_sel))
            SEL_MASK: mask_q <= io_val;
            SEL_TXV:  txv_q  <= io_val;
            SEL_RXV:  rxv_q  <= io_val;
            SEL_IO:   io_q   <= (io_q & ~io_ben) | (io_val & io_ben);
            default:  io_q   <= io_q;
         endcase
      end
   end

   assign auto_val = tx_mode ? txv_q : rxv_q;

   // per-bit steering between the automatic pattern and the plain register
   for (genvar b = 0; b < BANK_W; b++) begin : g_bit
      assign pin_out[b] = (auto_en && mask_q[b]) ? auto_val[b] : io_q[b];
   end

   assert_masked_write_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && wr_sel == 2'd3) |=> (((io_q ^ $past(io_q)) & ~$past(io_ben)) == '0));

   assert_disabled_shows_io_R4: assert property (@(posedge clk) disable iff (rst)
      !auto_en |-> (pin_out == io_q));

   assert_unselected_shows_io_R5: assert property (@(posedge clk) disable iff (rst)
      (((pin_out ^ io_q) & ~mask_q) == '0));

endmodule

// File: rtl/trx_pin_switcher.sv
module trx_pin_switcher
   import trx_sw_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 16,
   parameter int DLY_W     = 16,
   parameter int ADDR_W    = 5
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [BUS_W-1:0]            wr_data,
   input  logic                        fifo_empty,
   input  logic [NUM_BANKS*BANK_W-1:0] oe_in,
   output logic [NUM_BANKS*BANK_W-1:0] pin_out,
   output logic [NUM_BANKS*BANK_W-1:0] pin_oe
);

   localparam int PINS      = NUM_BANKS * BANK_W;
   localparam int CTRL_BASE = NUM_BANKS * REGS_PER_BANK;
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (BANK_W > BUS_W / 2) begin : g_chk_width
      $error("BANK_W must fit in half the write bus");
   end
   if (DLY_W > BUS_W) begin : g_chk_dly
      $error("DLY_W must not exceed the write bus");
   end
   if (CTRL_BASE + CTRL_REGS > ADDR_SPAN) begin : g_chk_addr
      $error("ADDR_W too small for the register map");
   end

   logic             auto_en_q;
   logic [DLY_W-1:0] rise_q, fall_q;
   logic             tx_mode;
   logic [NUM_BANKS-1:0] bank_hit;
   int unsigned      addr_u;

   assign addr_u = 32'(wr_addr);

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         bank_hit[b] = wr_en && (addr_u < CTRL_BASE) &&
                       ((addr_u / REGS_PER_BANK) == b);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         auto_en_q <= 1'b0;
         rise_q    <= '0;
         fall_q    <= '0;
      end else if (wr_en) begin
         if (addr_u == CTRL_BASE + CTRL_EN_OFS)   auto_en_q <= wr_data[0];
         if (addr_u == CTRL_BASE + CTRL_RISE_OFS) rise_q    <= wr_data[DLY_W-1:0];
         if (addr_u == CTRL_BASE + CTRL_FALL_OFS) fall_q    <= wr_data[DLY_W-1:0];
      end
   end

   trx_sw_dir_timer #(.DLY_W(DLY_W)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .tx_pending (~fifo_empty),
      .dly_rise   (rise_q),
      .dly_fall   (fall_q),
      .tx_mode    (tx_mode)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      trx_sw_bank #(.BANK_W(BANK_W)) u_bank (
         .clk     (clk),
         .rst     (rst),
         .wr_hit  (bank_hit[g]),
         .wr_sel  (wr_addr[1:0]),
         .wr_data (wr_data),
         .auto_en (auto_en_q),
         .tx_mode (tx_mode),
         .pin_out (pin_out[g*BANK_W +: BANK_W])
      );
   end

   assign pin_oe = oe_in;

   assert_oe_passthrough_R10: assert property (@(posedge clk) disable iff (rst)
      pin_oe == oe_in);

   assert_one_bank_per_write_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(bank_hit));

   assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr_u >= CTRL_BASE + CTRL_REGS) |=>
         ($stable(auto_en_q) && $stable(rise_q) && $stable(fall_q)));

   assert_reset_clears_R1: assert property (@(posedge clk)
      $past(rst) |-> (pin_out == '0));

endmodule

// File: tb/sim_trx_pin_switcher.sv
module sim_trx_pin_switcher;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        fifo_empty = 1'b1;
   logic [63:0] oe_in = 64'hF0F0_1234_00FF_A5A5;
   logic [63:0] pin_out, pin_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   trx_pin_switcher u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fifo_empty(fifo_empty), .oe_in(oe_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // {addr, data, fifo_empty, expected pin_out}
   localparam int NV = 15;
   localparam logic [101:0] VEC [NV] = '{
      {5'd3,  32'hFFFF_1234, 1'b1, 64'h0000_0000_0000_1234}, // R2 R3 full write
      {5'd3,  32'h00FF_ABCD, 1'b1, 64'h0000_0000_0000_12CD}, // R3 partial write
      {5'd0,  32'h0000_00F0, 1'b1, 64'h0000_0000_0000_12CD}, // R4 mask while disabled
      {5'd2,  32'h0000_0A0A, 1'b1, 64'h0000_0000_0000_12CD}, // R4
      {5'd1,  32'h0000_5050, 1'b1, 64'h0000_0000_0000_12CD}, // R4
      {5'd16, 32'h0000_0001, 1'b1, 64'h0000_0000_0000_120D}, // R5 R6 receive pattern
      {5'd31, 32'hFFFF_FFFF, 1'b0, 64'h0000_0000_0000_125D}, // R11 R6 transmit pattern
      {5'd7,  32'hFFFF_BEEF, 1'b0, 64'h0000_0000_BEEF_125D}, // R2 bank 1
      {5'd4,  32'h0000_FF00, 1'b0, 64'h0000_0000_00EF_125D}, // R5 bank 1 mask
      {5'd6,  32'h0000_3300, 1'b1, 64'h0000_0000_33EF_120D}, // R6 back to receive
      {5'd15, 32'hFFFF_8001, 1'b1, 64'h8001_0000_33EF_120D}, // R2 bank 3
      {5'd16, 32'h0000_0000, 1'b1, 64'h8001_0000_BEEF_12CD}, // R4 disable
      {5'd8,  32'h0000_FFFF, 1'b1, 64'h8001_0000_BEEF_12CD}, // R4 bank 2 mask
      {5'd16, 32'h0000_0001, 1'b1, 64'h8001_0000_33EF_120D}, // R5 re-enable
      {5'd11, 32'hFFFF_7777, 1'b1, 64'h8001_0000_33EF_120D}  // R5 fully selected bank
   };

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic step_check_nib(input string tag, input logic [3:0] exp);
      @(negedge clk);
      check(tag, {60'd0, pin_out[7:4]}, {60'd0, exp});
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset pin_out", pin_out, 64'd0);
      check("R10 oe during reset", pin_oe, oe_in);
      rst = 1'b0;
      @(negedge clk);
      check("R1 after release", pin_out, 64'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         wr_en = 1'b1;
         wr_addr = VEC[i][101:97];
         wr_data = VEC[i][96:65];
         fifo_empty = VEC[i][64];
         @(negedge clk);
         wr_en = 1'b0;
         check($sformatf("vector %0d (R2..R6, R11 table)", i), pin_out, VEC[i][63:0]);
         check("R10 oe pass", pin_oe, oe_in);
      end

      // R7 rise delay 5, R8 fall delay 3 ; bank 0 bits 7:4 show 5 in transmit, 0 in receive
      wr(5'd17, 32'd5);
      wr(5'd18, 32'd3);
      fifo_empty = 1'b0;
      for (int k = 0; k < 5; k++) step_check_nib("R7 still receive", 4'h0);
      step_check_nib("R7 transmit on edge D+1", 4'h5);
      fifo_empty = 1'b1;
      for (int k = 0; k < 3; k++) step_check_nib("R8 still transmit", 4'h5);
      step_check_nib("R8 receive on edge F+1", 4'h0);

      // R9 reversal before expiry restarts the wait
      fifo_empty = 1'b0;
      for (int k = 0; k < 3; k++) step_check_nib("R9 waiting", 4'h0);
      fifo_empty = 1'b1;
      step_check_nib("R9 no glitch on reversal", 4'h0);
      fifo_empty = 1'b0;
      for (int k = 0; k < 5; k++) step_check_nib("R9 full wait again", 4'h0);
      step_check_nib("R9 transmit after full wait", 4'h5);

      // R10 with enable changes and transmit mode
      oe_in = 64'h0123_4567_89AB_CDEF;
      @(negedge clk);
      check("R10 oe new value", pin_oe, 64'h0123_4567_89AB_CDEF);

      // R1 reset mid-traffic
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R1 mid-traffic reset", pin_out, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 enable cleared after reset", pin_out, 64'd0);
      wr(5'd0, 32'h0000_FFFF);
      wr(5'd1, 32'h0000_FFFF);
      check("R1 switching disabled after reset", pin_out, 64'd0);
      wr(5'd16, 32'd1);
      check("R1 delays cleared after reset", pin_out, 64'h0000_0000_0000_FFFF);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule